// File: doc/BRIEF.md
# Sequential Nonrestoring Unsigned Divider

This block divides one unsigned W-bit integer by another over several clock cycles. It settles one quotient digit per clock. On every step it adds or subtracts the divisor from the shifted running remainder, and the sign of that remainder picks the operation. No step ever restores a remainder. Each digit is worth +1 or −1. A −1 digit is recorded as a 0 bit and a +1 digit as a 1 bit. At the end, this signed-digit string is turned into an ordinary binary quotient. A final cycle then adds the divisor back if the remainder came out negative, and takes one from the quotient in that case.

A caller pulses `start` with the operands while `busy` is low. `busy` stays high for W+1 cycles: W iteration cycles and one correction cycle. `done` then pulses for one clock, and the quotient and remainder appear on the outputs at the same time. The outputs hold their values until the next result is written. If the divisor is zero, the block raises a flag rather than attempting a real division.

Top module: `nrd_divider`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done` and `div_zero` are 0 and `quot` and `rem` are all zeros.
- R2: A `start` sampled while `busy` is low captures `numer` and `denom`, and `busy` is 1 from the next cycle on.
- R3: `done` is 1 for exactly one cycle, in the (W+1)th cycle after the clock edge that captured `start`. `busy` is 0 in that cycle.
- R4: For a nonzero divisor D and numerator N, the results satisfy N = quot·D + rem with 0 ≤ rem < D. This holds when the divisor is 1, when it is the largest W-bit value, and when N < D.
- R5: Results are correct both when the uncorrected remainder ends negative, so that the correction cycle adds D back and lowers the quotient by one, and when it ends non-negative. This includes exact multiples, where rem = 0.
- R6: A zero divisor gives `div_zero` = 1 together with `done`, `quot` all ones and `rem` equal to the numerator.
- R7: A `start` that arrives while `busy` is high is ignored: it produces no extra `done`, and it does not change the result that is in progress.
- R8: `quot`, `rem` and `div_zero` keep their values between completions. A later division by a nonzero divisor clears `div_zero`.
- R9: A `start` given in the same cycle as `done` is accepted, so divisions can run back to back without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; honoured only while `busy` is low |
| numer | input | W | Unsigned numerator |
| denom | input | W | Unsigned divisor |
| quot | output | W | Quotient of the last completed division |
| rem | output | W | Remainder of the last completed division |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse when new results are valid |
| div_zero | output | 1 | The last completed division had a zero divisor |

## Verification
The operand patterns are chosen to separate the two branches of the correction cycle:
- exact multiples, which leave no remainder;
- pairs whose uncorrected remainder ends negative;
- divisors of 1 and of the largest value;
- numerators below the divisor.

A long pseudo-random run follows, mixing all magnitudes so that the add and subtract steps interleave in many orders. Zero-divisor requests are placed directly before a normal request, which shows whether the flag clears. Back-to-back requests, and a request made while the block is busy, show whether `start` is accepted or ignored at the right moments.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } nrd_state_e;

endpackage

// File: rtl/nrd_step.sv
// One nonrestoring iteration: shift in the next numerator bit, then add or
// subtract the divisor depending on the sign of the incoming remainder.
module nrd_step #(
    parameter int W = 8
) (
    input  logic [W:0]   rem_in,
    input  logic         num_bit,
    input  logic [W-1:0] den,
    output logic [W:0]   rem_out,
    output logic         digit
);
    logic [W:0] shifted;
    logic [W:0] den_ext;

    always_comb begin
        shifted = {rem_in[W-1:0], num_bit};
        den_ext = {1'b0, den};
        // Non-negative remainder: digit +1 (stored 1), subtract.
        // Negative remainder: digit -1 (stored 0), add.
        digit   = ~rem_in[W];
        if (digit) begin
            rem_out = shifted - den_ext;
        end else begin
            rem_out = shifted + den_ext;
        end
    end
endmodule

// File: rtl/nrd_fixup.sv
// Converts the stored digit pattern to binary and makes the remainder
// non-negative. Quotient = 2*P + 1 - 2^W, kept modulo 2^W.
module nrd_fixup #(
    parameter int W = 8
) (
    input  logic [W-1:0] digits,
    input  logic [W:0]   rem_raw,
    input  logic [W-1:0] den,
    input  logic         zero_den,
    output logic [W-1:0] quot_out,
    output logic [W-1:0] rem_out
);
    logic [W-1:0] quot_conv;
    logic [W:0]   rem_sum;

    always_comb begin
        quot_conv = {digits[W-2:0], 1'b1};
        rem_sum   = rem_raw + {1'b0, den};
        if (zero_den) begin
            quot_out = '1;
            rem_out  = rem_raw[W-1:0];
        end else if (rem_raw[W]) begin
            quot_out = quot_conv - W'(1);
            rem_out  = rem_sum[W-1:0];
        end else begin
            quot_out = quot_conv;
            rem_out  = rem_raw[W-1:0];
        end
    end
endmodule

// File: rtl/nrd_divider.sv
module nrd_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] numer,
    input  logic [W-1:0] denom,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic         busy,
    output logic         done,
    output logic         div_zero
);
    import nrd_pkg::*;

    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        nrd_state_e   st;
        logic [CW-1:0] cnt;
        logic [W-1:0] num;
        logic [W-1:0] den;
        logic [W:0]   acc;
        logic [W-1:0] dig;
        logic         zero;
        logic [W-1:0] quot;
        logic [W-1:0] rem;
        logic         zflag;
        logic         done;
    } nrd_regs_t;

    nrd_regs_t r_q, r_d;

    logic [W:0]   step_rem;
    logic         step_dig;
    logic [W-1:0] fix_quot;
    logic [W-1:0] fix_rem;
    logic [W-1:0] den_held;

    nrd_step #(.W(W)) step_i (
        .rem_in  (r_q.acc),
        .num_bit (r_q.num[W-1]),
        .den     (r_q.den),
        .rem_out (step_rem),
        .digit   (step_dig)
    );

    nrd_fixup #(.W(W)) fix_i (
        .digits   (r_q.dig),
        .rem_raw  (r_q.acc),
        .den      (r_q.den),
        .zero_den (r_q.zero),
        .quot_out (fix_quot),
        .rem_out  (fix_rem)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_RUN;
                    r_d.cnt  = '0;
                    r_d.num  = numer;
                    r_d.den  = denom;
                    r_d.acc  = '0;
                    r_d.dig  = '0;
                    r_d.zero = (denom == '0);
                end
            end
            ST_RUN: begin
                r_d.acc = step_rem;
                r_d.dig = {r_q.dig[W-2:0], step_dig};
                r_d.num = {r_q.num[W-2:0], 1'b0};
                if (r_q.cnt == CW'(W - 1)) begin
                    r_d.st = ST_FIX;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_FIX: begin
                r_d.quot  = fix_quot;
                r_d.rem   = fix_rem;
                r_d.zflag = r_q.zero;
                r_d.done  = 1'b1;
                r_d.st    = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign quot     = r_q.quot;
    assign rem      = r_q.rem;
    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign div_zero = r_q.zflag;
    assign den_held = r_q.den;

endmodule

// File: rtl/nrd_divider_chk.sv
module nrd_divider_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         div_zero,
    input logic [W-1:0] quot,
    input logic [W-1:0] rem,
    input logic [W-1:0] den_held
);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> (rem < den_held));

    // R6
    zero_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (&quot));

    // R8
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quot) && $stable(rem) && $stable(div_zero)));
endmodule

bind nrd_divider nrd_divider_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .div_zero (div_zero),
    .quot     (quot),
    .rem      (rem),
    .den_held (den_held)
);

// File: tb/nrd_divider_tb_top.sv
module nrd_divider_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] numer = '0;
    logic [W-1:0] denom = '0;
    logic [W-1:0] quot, rem;
    logic         busy, done, div_zero;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int pushed = 0;
    int seen = 0;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         z;
        int           due;
    } exp_t;

    exp_t sb[$];

    nrd_divider #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .numer(numer), .denom(denom),
        .quot(quot), .rem(rem), .busy(busy), .done(done), .div_zero(div_zero)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: waits for an idle block, issues a request, records the expectation.
    task automatic issue(input logic [W-1:0] n, input logic [W-1:0] d);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        numer = n;
        denom = d;
        start = 1'b1;
        if (d == '0) begin
            e.q = '1; e.r = n; e.z = 1'b1;
        end else begin
            e.q = n / d; e.r = n % d; e.z = 1'b0;
        end
        e.due = cyc + W + 2;
        sb.push_back(e);
        pushed++;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: compares each completion with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            seen++;
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(quot == e.q, "R4/R5/R6 quotient", quot, e.q);
                check(rem == e.r, "R4/R5/R6 remainder", rem, e.r);
                check(div_zero == e.z, "R6/R8 div_zero", div_zero, e.z);
                check(cyc == e.due, "R3 done latency", cyc, e.due);
                check(!busy, "R3 busy low at done", busy, 0);
            end
        end
    end

    initial begin
        int lfsr;
        lfsr = 16'hACE1;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && !div_zero, "R1 flags in reset", {busy, done, div_zero}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(quot == 0 && rem == 0, "R1 outputs after reset", {quot, rem}, 0);
        check(!busy && !done, "R1 idle after reset", {busy, done}, 0);

        // R2 busy follows start
        issue(8'd100, 8'd7);
        check(busy, "R2 busy after start", busy, 1);

        // R4 boundaries, R5 exact multiples and negative-correction pairs, R9 back to back
        issue(8'd255, 8'd1);
        issue(8'd255, 8'd255);
        issue(8'd3, 8'd200);
        issue(8'd0, 8'd9);
        issue(8'd144, 8'd12);
        issue(8'd8, 8'd3);
        issue(8'd7, 8'd2);
        issue(8'd254, 8'd255);
        issue(8'd128, 8'd129);

        // R6 zero divisor, then R8 flag clears on the next normal division
        issue(8'd77, 8'd0);
        issue(8'd50, 8'd5);

        // R7 start while busy is ignored
        issue(8'd200, 8'd3);
        @(negedge clk);
        numer = 8'd9; denom = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        // R8 hold: outputs keep values after completion
        while (busy || sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(quot == 8'd66 && rem == 8'd2, "R8 outputs held", {quot, rem}, {8'd66, 8'd2});

        // Pseudo-random sweep for R4/R5
        for (int i = 0; i < 300; i++) begin
            lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
            issue(lfsr[7:0], (i % 37 == 0) ? 8'd0 : lfsr[15:8]);
        end

        while (busy || sb.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check(seen == pushed, "R7 completion count", seen, pushed);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule